// File: doc/BRIEF.md
# Asynchronous Static Memory Read Sequencer

This block times read cycles on an external asynchronous static memory such as SRAM, ROM or NOR flash. A client presents an address, a bank number and a sequential hint; when the sequencer is idle it takes the request and drives chip select, output enable and the address pins. It then samples the memory data at the end of the wait period and hands it back with a one-cycle valid pulse.

Each of the four banks has its own output-enable delay, first-read wait code, page wait code and extended-wait enable. There is also one shared extended wait code. All of these are plain inputs. The sequencer copies them when an access starts. A read that carries the sequential hint and stays inside the four-word page of the previous access to the same bank uses the shorter page wait.

Top module: `static_rd_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `mem_cs_n` and `mem_oe_n` are 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `mem_cs_n` is 0 and `mem_addr` carries the request address, and the address stays unchanged for every cycle that chip select is low.
- R3: A non-sequential read on a bank with extended wait off holds `mem_cs_n` low for (read code + 1) cycles when the 5-bit read code is 0 to 30.
- R4: A read code of 31 (all ones) holds chip select low for 32 cycles.
- R5: When the bank's `cfg_ext_en` bit is 1, a non-page read lasts (`cfg_ext_wait` + 1) cycles and the read code has no effect.
- R6: A read is a page hit only when all of these hold: `req_seq` is 1, a previous access exists, the previous access used the same bank, and `req_addr[AW-1:2]` equals that access's `req_addr[AW-1:2]`. A page hit lasts (page code + 1) cycles. Any other read uses R3 to R5.
- R7: With a 4-bit output-enable delay d, where cycle 0 is the first chip-select-low cycle, `mem_oe_n` is 0 in cycles d through the last cycle of the access and 1 before cycle d. If d is not less than the access length, output enable never asserts.
- R8: `mem_cs_n` and `mem_oe_n` rise together at the end of the access. In the next cycle `rd_valid` is 1 for exactly one cycle, `rd_data` equals `mem_rdata` as sampled in the last chip-select-low cycle, and `req_ready` is 1.
- R9: Bank b takes its settings from bits [b*W +: W] of each packed configuration bus, and each bank's timing is independent of the settings of the other banks.
- R10: A configuration change made after a request is taken has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_bank | input | BW (2) | Bank number |
| req_addr | input | AW (16) | Word address |
| req_seq | input | 1 | Sequential hint for page reads |
| cfg_oe_dly | input | NB*OEW (16) | Output-enable delay per bank |
| cfg_rd_wait | input | NB*RDW (20) | First-read wait code per bank |
| cfg_pg_wait | input | NB*PGW (20) | Page wait code per bank |
| cfg_ext_en | input | NB (4) | Extended-wait enable per bank |
| cfg_ext_wait | input | XW (8) | Shared extended wait code |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW (16) | Memory address |
| mem_rdata | input | DW (16) | Memory read data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW (16) | Captured read data |

## Verification
The assertions assume that reset is held high for at least one clock at start-up, that `req_valid` is driven to a known level at every edge, and that the bank number is always a legal index. With four banks, every 2-bit value is a legal index. The bench drives requests only away from the clock edge. It keeps `req_valid` high for one edge at a time, while `req_ready` is 1. It changes the configuration either between accesses or, in the R10 case only, during an access whose expected timing was already recorded. The memory model returns data that depends on the address alone, so a captured word shows whether the sample was taken with the address stable.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } srs_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/srs_page_trk.sv
module srs_page_trk #(
  parameter int AW = 16,
  parameter int BW = 2,
  parameter int PAGE_WORDS = 4,
  localparam int PB = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [BW-1:0] req_bank,
  input  logic [AW-1:0] req_addr,
  input  logic          req_seq,
  output logic          hit
);
  logic [AW-PB-1:0] last_page;
  logic [BW-1:0]    last_bank;
  logic             last_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_page <= '0;
      last_bank <= '0;
      last_vld  <= 1'b0;
    end else if (take) begin
      last_page <= req_addr[AW-1:PB];
      last_bank <= req_bank;
      last_vld  <= 1'b1;
    end
  end

  assign hit = req_seq && last_vld && (req_bank == last_bank)
               && (req_addr[AW-1:PB] == last_page);
endmodule

// File: rtl/srs_bank_cfg.sv
module srs_bank_cfg #(
  parameter int NB  = 4,
  parameter int OEW = 4,
  parameter int RDW = 5,
  parameter int PGW = 5,
  parameter int XW  = 8,
  parameter int LW  = 9,
  localparam int BW = $clog2(NB)
) (
  input  logic [BW-1:0]     bank,
  input  logic              page_hit,
  input  logic [NB*OEW-1:0] cfg_oe_dly,
  input  logic [NB*RDW-1:0] cfg_rd_wait,
  input  logic [NB*PGW-1:0] cfg_pg_wait,
  input  logic [NB-1:0]     cfg_ext_en,
  input  logic [XW-1:0]     cfg_ext_wait,
  output logic [LW-1:0]     len,
  output logic [LW-1:0]     dly
);
  logic [OEW-1:0] oe_arr [NB];
  logic [RDW-1:0] rd_arr [NB];
  logic [PGW-1:0] pg_arr [NB];

  for (genvar b = 0; b < NB; b++) begin : g_unpack
    assign oe_arr[b] = cfg_oe_dly[b*OEW +: OEW];
    assign rd_arr[b] = cfg_rd_wait[b*RDW +: RDW];
    assign pg_arr[b] = cfg_pg_wait[b*PGW +: PGW];
  end

  always_comb begin
    if (page_hit)
      len = LW'(pg_arr[bank]) + LW'(1);
    else if (cfg_ext_en[bank])
      len = LW'(cfg_ext_wait) + LW'(1);
    else
      len = LW'(rd_arr[bank]) + LW'(1);
    dly = LW'(oe_arr[bank]);
  end
endmodule

// File: rtl/static_rd_seq.sv
module static_rd_seq
  import srs_pkg::*;
#(
  parameter int NB  = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int OEW = 4,
  parameter int RDW = 5,
  parameter int PGW = 5,
  parameter int XW  = 8,
  parameter int PAGE_WORDS = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BW-1:0]     req_bank,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_seq,
  input  logic [NB*OEW-1:0] cfg_oe_dly,
  input  logic [NB*RDW-1:0] cfg_rd_wait,
  input  logic [NB*PGW-1:0] cfg_pg_wait,
  input  logic [NB-1:0]     cfg_ext_en,
  input  logic [XW-1:0]     cfg_ext_wait,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int LW = imax(imax(RDW, PGW), imax(XW, OEW)) + 1;

  srs_state_e    state;
  logic [LW-1:0] cnt, len_q, dly_q, len_n, dly_n;
  logic          take, page_hit;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_ready && req_valid;

  srs_page_trk #(.AW(AW), .BW(BW), .PAGE_WORDS(PAGE_WORDS)) u_trk (
    .clk(clk), .rst(rst), .take(take), .req_bank(req_bank),
    .req_addr(req_addr), .req_seq(req_seq), .hit(page_hit)
  );

  srs_bank_cfg #(.NB(NB), .OEW(OEW), .RDW(RDW), .PGW(PGW), .XW(XW), .LW(LW)) u_cfg (
    .bank(req_bank), .page_hit(page_hit), .cfg_oe_dly(cfg_oe_dly),
    .cfg_rd_wait(cfg_rd_wait), .cfg_pg_wait(cfg_pg_wait),
    .cfg_ext_en(cfg_ext_en), .cfg_ext_wait(cfg_ext_wait),
    .len(len_n), .dly(dly_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_cs_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_addr <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cnt      <= '0;
      len_q    <= '0;
      dly_q    <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state    <= ST_RUN;
            mem_cs_n <= 1'b0;
            mem_oe_n <= (dly_n != '0);
            mem_addr <= req_addr;
            cnt      <= '0;
            len_q    <= len_n;
            dly_q    <= dly_n;
          end
        end
        ST_RUN: begin
          if (cnt == len_q - LW'(1)) begin
            state    <= ST_IDLE;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            rd_valid <= 1'b1;
            rd_data  <= mem_rdata;
          end else begin
            cnt      <= cnt + LW'(1);
            mem_oe_n <= ((cnt + LW'(1)) < dly_q);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic          rd_valid
);
  p_oe_in_cs_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_cs_n);

  p_oe_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!mem_oe_n) && !mem_cs_n) |-> !mem_oe_n);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_end_valid_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |-> (rd_valid && mem_oe_n));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_oe_n));
endmodule

bind static_rd_seq srs_chk #(.AW(AW)) u_srs_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .rd_valid(rd_valid)
);

// File: tb/test_static_rd_seq.sv
module test_static_rd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_seq = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  oe_c [4];
  logic [4:0]  rd_c [4];
  logic [4:0]  pg_c [4];
  logic [3:0]  ext_en = '0;
  logic [7:0]  ext_w = '0;
  logic [15:0] cfg_oe;
  logic [19:0] cfg_rd, cfg_pg;
  logic        cs_n, oe_n, rd_valid;
  logic [15:0] mem_addr, mem_rdata, rd_data;

  for (genvar b = 0; b < 4; b++) begin : g_pack
    assign cfg_oe[b*4 +: 4] = oe_c[b];
    assign cfg_rd[b*5 +: 5] = rd_c[b];
    assign cfg_pg[b*5 +: 5] = pg_c[b];
  end

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  assign mem_rdata = mem_f(mem_addr);

  static_rd_seq i_static_rd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr), .req_seq(req_seq),
    .cfg_oe_dly(cfg_oe), .cfg_rd_wait(cfg_rd), .cfg_pg_wait(cfg_pg),
    .cfg_ext_en(ext_en), .cfg_ext_wait(ext_w), .mem_cs_n(cs_n),
    .mem_oe_n(oe_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct {
    int          len;
    int          oe_at;
    logic [15:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit lv = 1'b0;
  logic [1:0]  lb;
  logic [13:0] lp;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] b, input logic [15:0] a, input logic s,
                       input string tag);
    exp_t e;
    bit hit;
    hit = s && lv && (b == lb) && (a[15:2] == lp);
    if (hit) e.len = pg_c[b] + 1;
    else if (ext_en[b]) e.len = ext_w + 1;
    else e.len = rd_c[b] + 1;
    e.oe_at = (oe_c[b] < e.len) ? int'(oe_c[b]) : -1;
    e.addr = a;
    e.tag = tag;
    sb.push_back(e);
    lv = 1'b1; lb = b; lp = a[15:2];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_bank = b; req_addr = a; req_seq = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_seq = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures each access and compares against the scoreboard
  int cyc = 0, oe_first = -1;
  bit addr_bad = 1'b0;
  logic [15:0] addr0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_n) begin
        if (cyc == 0) addr0 = mem_addr;
        else if (mem_addr != addr0) addr_bad = 1'b1;
        if (!oe_n && oe_first < 0) oe_first = cyc;
        cyc++;
      end
      if (rd_valid) begin
        if (sb.size() == 0) begin
          check("R8 unexpected rd_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " length"}, cyc, e.len);
          check("R7 oe start", oe_first, e.oe_at);
          check("R2 address", int'(addr0), int'(e.addr));
          check("R2 address held", int'(addr_bad), 0);
          check("R8 rd_data", int'(rd_data), int'(mem_f(e.addr)));
          check("R8 ready with valid", int'(req_ready && cs_n && oe_n), 1);
        end
        cyc = 0; oe_first = -1; addr_bad = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    oe_c[0] = 0;  rd_c[0] = 31; pg_c[0] = 2;
    oe_c[1] = 2;  rd_c[1] = 5;  pg_c[1] = 1;
    oe_c[2] = 15; rd_c[2] = 3;  pg_c[2] = 0;
    oe_c[3] = 3;  rd_c[3] = 0;  pg_c[3] = 4;
    ext_en = 4'b1000; ext_w = 8'd9;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", int'(cs_n), 1);
    check("R1 oe_n in reset", int'(oe_n), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n after reset", int'(cs_n), 1);
    check("R1 oe_n after reset", int'(oe_n), 1);
    check("R1 rd_valid after reset", int'(rd_valid), 0);
    check("R1 req_ready after reset", int'(req_ready), 1);

    issue(2'd0, 16'h1234, 1'b0, "R4 code 31");
    issue(2'd1, 16'h0040, 1'b0, "R3 code 5");
    issue(2'd1, 16'h0041, 1'b1, "R6 page hit");
    issue(2'd1, 16'h0043, 1'b1, "R6 page hit end");
    issue(2'd1, 16'h0044, 1'b1, "R6 new page");
    issue(2'd1, 16'h0045, 1'b0, "R6 no seq flag");
    issue(2'd2, 16'h0046, 1'b1, "R6 other bank");
    issue(2'd2, 16'h0047, 1'b1, "R9 bank2 page 0");
    issue(2'd3, 16'h0300, 1'b0, "R5 ext wait");
    issue(2'd0, 16'h0010, 1'b0, "R4 again");
    issue(2'd0, 16'h0011, 1'b1, "R9 bank0 page");
    drain();

    rd_c[2] = 0; oe_c[2] = 0; ext_w = 8'd2;
    @(negedge clk);
    issue(2'd2, 16'hBEEF, 1'b0, "R3 code 0");
    issue(2'd3, 16'h0777, 1'b0, "R5 ext short");
    rd_c[1] = 30;
    issue(2'd1, 16'hA000, 1'b0, "R3 code 30");
    drain();

    rd_c[1] = 6; oe_c[1] = 4;
    issue(2'd1, 16'h5550, 1'b0, "R10 latched");
    rd_c[1] = 20; oe_c[1] = 0;
    drain();
    check("R10 access count", int'(sb.size()), 0);
    rd_c[1] = 5; oe_c[1] = 2;
    issue(2'd1, 16'h6000, 1'b0, "R9 bank1 restored");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule